// File: doc/BRIEF.md
# Input Power-Path Protection Sequencer

This block holds the digital timing and control for a load switch that sits between an external supply input and a protected system rail. It takes comparator flags for "input above the low threshold", "input above the high threshold" and "load overcurrent", an active-low enable, a binary junction temperature in degrees Celsius, and a strap that selects how power-good is qualified. It drives the enable of the gate pump for the internal pass switch, two select lines for the pull-up and pull-down that bias the gate of an external reverse-blocking transistor, and the pull-low control of an active-low open-drain power-good flag.

The switch turns on only after the input has been continuously valid for a qualification period. It is shut off at once when the input leaves the valid window, when enable goes high, or when the die overheats. An overcurrent that lasts through a short blanking delay turns the switch off, and a timed retry loop then tries it again. Power-good runs on its own qualification timer, so it does not follow the switch. All time intervals count ticks from a shared prescaler, and every count is a parameter so a short setting can be used in simulation.

Top module: `pwr_path_seq`

## Requirements
- R1: `pump_en` is 1 only while the synchronized input is above the low threshold and below the high threshold, enable is low, and the thermal latch is clear.
- R2: When the input leaves the valid window, `pump_en` drops in the cycle that the synchronized flag changes. No debounce is applied to turn-off.
- R3: After the switch conditions become true, `pump_en` rises only after they have held for QUAL_TICKS prescaler ticks. Any break during that time restarts the count from zero.
- R4: An overcurrent flag that stays high for BLANK_CYC clock cycles while the switch is on turns the switch off. A shorter pulse leaves the switch on.
- R5: After an overcurrent turn-off, the switch is retried after RETRY_TICKS ticks, with no new qualification. If the overcurrent is gone it stays on. If the overcurrent persists, the off/retry cycle repeats.
- R6: With `en_n`=1: `pump_en`=0, `gp_pu_sel`=1, `gp_pd_sel`=0.
- R7: With `en_n`=0 and the input above the low threshold: `gp_pd_sel`=1 and `gp_pu_sel`=0. With `en_n`=0 and the input below the low threshold, both selects are 0.
- R8: `pgood_pull`=1 means the flag is pulled low (asserted). With `pg_window`=1, it asserts after the input has stayed inside both thresholds for PG_TICKS ticks. With `pg_window`=0, it asserts after the input has stayed above the low threshold for PG_TICKS ticks, whatever the high comparator says.
- R9: `pgood_pull` returns to 0 in the cycle the synchronized low-threshold flag falls. With `pg_window`=1 it also returns to 0 when the synchronized high-threshold flag rises.
- R10: The thermal latch sets when `temp_c` > TRIP_C (150), which forces `pump_en` to 0. It clears only when `temp_c` <= TRIP_C − HYST_C (110), after which the switch requalifies.
- R11: During and after reset, `pump_en`=0, `pgood_pull`=0 and `gp_pu_sel`=1.
- R12: `en_n`, `uv_ok_a`, `ov_hi_a` and `oc_a` each pass through a two-flop synchronizer. A change on one of them reaches the combinational outputs after exactly two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_n | input | 1 | Active-low enable (asynchronous) |
| uv_ok_a | input | 1 | Input is above the low threshold (asynchronous) |
| ov_hi_a | input | 1 | Input is above the high threshold (asynchronous) |
| oc_a | input | 1 | Load overcurrent flag (asynchronous) |
| temp_c | input | TEMP_W | Junction temperature in °C, synchronous to clk |
| pg_window | input | 1 | Strap: 1 = power-good uses the full window, 0 = low threshold only |
| pump_en | output | 1 | Gate pump enable for the internal switch |
| gp_pu_sel | output | 1 | Selects the external gate pull-up |
| gp_pd_sel | output | 1 | Selects the external gate pull-down |
| pgood_pull | output | 1 | 1 pulls the open-drain power-good low (asserted) |

## Verification
The bench checks that a short drop out of the window during qualification restarts the full count. A design that resumed the old count would turn on too early. It drives overcurrent pulses shorter than the blanking delay and expects the switch to stay on, then holds a persistent overcurrent and counts repeated retry turn-ons. A design without the loop would latch off, and one that skipped blanking would drop on every glitch. It holds the temperature between the trip and release points and expects no restart, and it checks that exactly 150 °C does not trip. It also checks that in low-threshold mode power-good asserts even while the high comparator is set, which separates the two power-good modes.

// File: rtl/pps_pkg.sv
package pps_pkg;

  typedef enum logic [1:0] {
    SW_OFF   = 2'd0,
    SW_QUAL  = 2'd1,
    SW_ON    = 2'd2,
    SW_RETRY = 2'd3
  } sw_state_e;

  // Input is inside the valid supply window.
  function automatic logic window_ok(input logic above_uv, input logic above_ov);
    return above_uv & ~above_ov;
  endfunction

  // Condition the power-good timer qualifies, chosen by the strap.
  function automatic logic pg_qualifier(input logic full_window,
                                        input logic above_uv,
                                        input logic above_ov);
    return full_window ? window_ok(above_uv, above_ov) : above_uv;
  endfunction

  // Thermal latch with hysteresis; written as temp + hyst <= trip to avoid underflow.
  function automatic logic thermal_next(input logic        hot_q,
                                        input logic [31:0] temp,
                                        input logic [31:0] trip,
                                        input logic [31:0] hyst);
    if (temp > trip)             return 1'b1;
    else if (temp + hyst <= trip) return 1'b0;
    else                          return hot_q;
  endfunction

endpackage

// File: rtl/pps_sync.sv
module pps_sync #(
  parameter int           W       = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[b];
        sync_q <= RST_VAL[b];
      end else begin
        meta_q <= d_async[b];
        sync_q <= meta_q;
      end
    end
    assign q_sync[b] = sync_q;
  end
endmodule

// File: rtl/pps_tick.sv
module pps_tick #(
  parameter int DIV = 100000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] TOP = CW'(DIV - 1);

  if (DIV > 1) begin : g_div
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk) begin
      if (!rst_n)            cnt_q <= '0;
      else if (cnt_q == TOP) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
    end
    assign tick = (cnt_q == TOP);
  end else begin : g_pass
    logic run_q;
    always_ff @(posedge clk) run_q <= rst_n;
    assign tick = run_q;
  end
endmodule

// File: rtl/pps_timer.sv
module pps_timer #(
  parameter int LIMIT = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic step,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  assign done = (cnt_q == LIM);

  always_ff @(posedge clk) begin
    if (!rst_n || !run)      cnt_q <= '0;
    else if (step && !done)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwr_path_seq.sv
module pwr_path_seq
  import pps_pkg::*;
#(
  parameter int          PRESCALE    = 100000,
  parameter int          QUAL_TICKS  = 15,
  parameter int          RETRY_TICKS = 15,
  parameter int          PG_TICKS    = 15,
  parameter int          BLANK_CYC   = 1000,
  parameter int          TEMP_W      = 8,
  parameter int unsigned TRIP_C      = 150,
  parameter int unsigned HYST_C      = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_n,
  input  logic              uv_ok_a,
  input  logic              ov_hi_a,
  input  logic              oc_a,
  input  logic [TEMP_W-1:0] temp_c,
  input  logic              pg_window,
  output logic              pump_en,
  output logic              gp_pu_sel,
  output logic              gp_pd_sel,
  output logic              pgood_pull
);
  localparam int NSYNC = 4;
  localparam logic [NSYNC-1:0] SYNC_RST = NSYNC'(1); // enable reads "off" in reset

  // Synchronized inputs
  logic [NSYNC-1:0] s_q;
  logic en_s, uv_s, ov_s, oc_s;

  pps_sync #(.W(NSYNC), .RST_VAL(SYNC_RST)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async({oc_a, ov_hi_a, uv_ok_a, en_n}),
    .q_sync (s_q)
  );
  assign en_s = s_q[0];
  assign uv_s = s_q[1];
  assign ov_s = s_q[2];
  assign oc_s = s_q[3];

  // Time base
  logic tick;
  pps_tick #(.DIV(PRESCALE)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

  // Thermal latch
  logic hot;
  always_ff @(posedge clk) begin
    if (!rst_n) hot <= 1'b0;
    else        hot <= thermal_next(hot, 32'(temp_c), 32'(TRIP_C), 32'(HYST_C));
  end

  // Named events
  logic win_ok, allowed, pg_cond;
  logic deb_done, retry_done, blank_done, pg_done, blank_hit;
  sw_state_e st_q, st_d;

  assign win_ok  = window_ok(uv_s, ov_s);
  assign allowed = win_ok & ~en_s & ~hot;
  assign pg_cond = pg_qualifier(pg_window, uv_s, ov_s);

  pps_timer #(.LIMIT(QUAL_TICKS)) u_qual (
    .clk(clk), .rst_n(rst_n), .run(st_q == SW_QUAL), .step(tick), .done(deb_done));

  pps_timer #(.LIMIT(RETRY_TICKS)) u_retry (
    .clk(clk), .rst_n(rst_n), .run(st_q == SW_RETRY), .step(tick), .done(retry_done));

  pps_timer #(.LIMIT(BLANK_CYC)) u_blank (
    .clk(clk), .rst_n(rst_n), .run((st_q == SW_ON) & oc_s), .step(1'b1), .done(blank_done));

  pps_timer #(.LIMIT(PG_TICKS)) u_pg (
    .clk(clk), .rst_n(rst_n), .run(pg_cond), .step(tick), .done(pg_done));

  assign blank_hit = (st_q == SW_ON) & allowed & blank_done;

  // Switch sequencer
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SW_OFF:   if (allowed) st_d = SW_QUAL;
      SW_QUAL:  if (!allowed) st_d = SW_OFF;
                else if (deb_done) st_d = SW_ON;
      SW_ON:    if (!allowed) st_d = SW_OFF;
                else if (blank_done) st_d = SW_RETRY;
      SW_RETRY: if (!allowed) st_d = SW_OFF;
                else if (retry_done) st_d = SW_ON;
      default:  st_d = SW_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= SW_OFF;
    else        st_q <= st_d;
  end

  // Outputs: turn-off paths are combinational on the synchronized flags
  assign pump_en    = (st_q == SW_ON) & allowed;
  assign gp_pu_sel  = en_s;
  assign gp_pd_sel  = ~en_s & uv_s;
  assign pgood_pull = pg_done & pg_cond;

endmodule

// File: rtl/pps_chk.sv
module pps_chk (
  input logic clk,
  input logic rst_n,
  input logic en_s,
  input logic uv_s,
  input logic ov_s,
  input logic hot,
  input logic pg_window,
  input logic win_ok,
  input logic pump_en,
  input logic gp_pu_sel,
  input logic gp_pd_sel,
  input logic pgood_pull,
  input logic blank_hit,
  input logic deb_done,
  input logic retry_done
);
  a_r1_pump_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    pump_en |-> (uv_s && !ov_s && !en_s && !hot));

  a_r10_hot_blocks_pump: assert property (@(posedge clk) disable iff (!rst_n)
    hot |-> !pump_en);

  a_r3_rise_after_timer: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pump_en) |-> $past(deb_done || retry_done));

  a_r4_blank_turns_off: assert property (@(posedge clk) disable iff (!rst_n)
    blank_hit |=> !pump_en);

  a_r6_disabled_state: assert property (@(posedge clk) disable iff (!rst_n)
    en_s |-> (!pump_en && gp_pu_sel && !gp_pd_sel));

  a_r7_pulldown_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_s && uv_s) |-> (gp_pd_sel && !gp_pu_sel));

  a_r9_pg_low_release: assert property (@(posedge clk) disable iff (!rst_n)
    !uv_s |-> !pgood_pull);

  a_r9_pg_high_release: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_window && !win_ok) |-> !pgood_pull);

  a_r6_selects_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(gp_pu_sel && gp_pd_sel));
endmodule

bind pwr_path_seq pps_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en_s      (en_s),
  .uv_s      (uv_s),
  .ov_s      (ov_s),
  .hot       (hot),
  .pg_window (pg_window),
  .win_ok    (win_ok),
  .pump_en   (pump_en),
  .gp_pu_sel (gp_pu_sel),
  .gp_pd_sel (gp_pd_sel),
  .pgood_pull(pgood_pull),
  .blank_hit (blank_hit),
  .deb_done  (deb_done),
  .retry_done(retry_done)
);

// File: tb/pwr_path_seq_bench.sv
`timescale 1ns/1ps
module pwr_path_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en_n, uv, ov, oc, wm;
  logic [7:0] temp;
  logic       pump_en, gp_pu_sel, gp_pd_sel, pgood_pull;

  int n_chk = 0;
  int n_bad = 0;
  bit rnd_on = 1'b0;
  logic h1_en = 1'b1, h1_uv = 1'b0, h1_ov = 1'b0;
  logic h2_en = 1'b1, h2_uv = 1'b0, h2_ov = 1'b0;

  always #5 clk = ~clk;

  pwr_path_seq #(
    .PRESCALE(4), .QUAL_TICKS(15), .RETRY_TICKS(15), .PG_TICKS(15),
    .BLANK_CYC(3), .TEMP_W(8), .TRIP_C(150), .HYST_C(40)
  ) u_pwr_path_seq (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .uv_ok_a(uv), .ov_hi_a(ov),
    .oc_a(oc), .temp_c(temp), .pg_window(wm), .pump_en(pump_en),
    .gp_pu_sel(gp_pu_sel), .gp_pd_sel(gp_pd_sel), .pgood_pull(pgood_pull)
  );

  function automatic logic f_win(input logic u, input logic o); return u && !o; endfunction
  function automatic logic f_pu(input logic e); return e; endfunction
  function automatic logic f_pd(input logic e, input logic u); return !e && u; endfunction
  function automatic logic f_pg(input logic w, input logic u, input logic o);
    return w ? f_win(u, o) : u;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  // One cycle; sample at the falling edge, history models the two-flop delay (R12)
  task automatic tick();
    @(negedge clk);
    h2_en = h1_en; h2_uv = h1_uv; h2_ov = h1_ov;
    h1_en = en_n;  h1_uv = uv;    h1_ov = ov;
    if (rnd_on) begin
      chk("R6 pull-up select", gp_pu_sel, f_pu(h2_en));
      chk("R7 pull-down select", gp_pd_sel, f_pd(h2_en, h2_uv));
      if (pump_en) chk("R1 pump outside window", f_win(h2_uv, h2_ov) && !h2_en, 1'b1);
      if (pgood_pull) chk("R9 pgood without condition", f_pg(wm, h2_uv, h2_ov), 1'b1);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int rises;
    logic prev;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; en_n = 1'b1; uv = 1'b0; ov = 1'b0; oc = 1'b0; wm = 1'b1; temp = 8'd25;
    wait_n(5);
    chk("R11 reset pump", pump_en, 1'b0);
    chk("R11 reset pgood", pgood_pull, 1'b0);
    chk("R11 reset pull-up", gp_pu_sel, 1'b1);
    rst_n = 1'b1;
    wait_n(3);
    chk("R11 idle pump", pump_en, 1'b0);

    // R12 latency and R7 selects
    en_n = 1'b0; uv = 1'b1;
    tick();
    chk("R12 one edge not visible", gp_pd_sel, 1'b0);
    tick();
    chk("R12 two edges visible", gp_pd_sel, 1'b1);
    chk("R7 pull-up off", gp_pu_sel, 1'b0);

    // R3 qualification and R8 window mode
    wait_n(48);
    chk("R3 no early turn-on", pump_en, 1'b0);
    wait_n(20);
    chk("R3 turn-on after qualification", pump_en, 1'b1);
    chk("R8 pgood window mode", pgood_pull, 1'b1);

    // R2 / R9 overvoltage
    ov = 1'b1;
    wait_n(2);
    chk("R2 immediate turn-off", pump_en, 1'b0);
    chk("R9 window release on high", pgood_pull, 1'b0);

    // R8 lower-threshold mode ignores the high comparator
    wm = 1'b0;
    wait_n(70);
    chk("R8 pgood low-threshold mode", pgood_pull, 1'b1);
    chk("R1 pump off above high", pump_en, 1'b0);

    // R9 / R7 below low threshold
    uv = 1'b0;
    wait_n(2);
    chk("R9 release below low", pgood_pull, 1'b0);
    chk("R7 both selects off", gp_pd_sel | gp_pu_sel, 1'b0);

    // R3 restart on a break
    wm = 1'b1; uv = 1'b1; ov = 1'b0;
    wait_n(40);
    ov = 1'b1;
    wait_n(5);
    ov = 1'b0;
    wait_n(50);
    chk("R3 break restarts count", pump_en, 1'b0);
    wait_n(25);
    chk("R3 on after restarted count", pump_en, 1'b1);

    // R4 short pulse ignored
    oc = 1'b1;
    wait_n(2);
    oc = 1'b0;
    wait_n(10);
    chk("R4 short pulse ignored", pump_en, 1'b1);

    // R4 blanking then R5 retry timing
    oc = 1'b1;
    wait_n(12);
    chk("R4 overcurrent turn-off", pump_en, 1'b0);
    oc = 1'b0;
    wait_n(35);
    chk("R5 no early retry", pump_en, 1'b0);
    wait_n(40);
    chk("R5 retry turn-on", pump_en, 1'b1);

    // R5 repeating loop under persistent overcurrent
    oc = 1'b1;
    rises = 0; prev = pump_en;
    for (int i = 0; i < 300; i++) begin
      tick();
      if (pump_en && !prev) rises++;
      prev = pump_en;
    end
    chk("R5 retry loop repeats", rises >= 2, 1'b1);
    oc = 1'b0;
    wait_n(80);
    chk("R5 stays on after fault clears", pump_en, 1'b1);
    wait_n(100);
    chk("R5 still on", pump_en, 1'b1);

    // R6 enable high
    en_n = 1'b1;
    wait_n(2);
    chk("R6 pump off", pump_en, 1'b0);
    chk("R6 pull-up on", gp_pu_sel, 1'b1);
    chk("R6 pull-down off", gp_pd_sel, 1'b0);
    en_n = 1'b0;
    wait_n(75);
    chk("R6 re-enable", pump_en, 1'b1);

    // R10 thermal hysteresis
    temp = 8'd151;
    wait_n(2);
    chk("R10 trip", pump_en, 1'b0);
    temp = 8'd120;
    wait_n(100);
    chk("R10 held inside hysteresis", pump_en, 1'b0);
    temp = 8'd110;
    wait_n(80);
    chk("R10 restart after cooling", pump_en, 1'b1);
    temp = 8'd150;
    wait_n(5);
    chk("R10 exactly trip point stays on", pump_en, 1'b1);
    temp = 8'd25;

    // Random phase with per-cycle invariant checks
    rnd_on = 1'b1;
    for (int seg = 0; seg < 150; seg++) begin
      uv   = ($urandom % 10) < 8;
      ov   = ($urandom % 10) < 2;
      en_n = ($urandom % 20) < 3;
      oc   = ($urandom % 20) == 0;
      wm   = $urandom % 2;
      wait_n(1 + ($urandom % 40));
    end
    rnd_on = 1'b0;

    summary();
    $finish;
  end
endmodule